// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit with Alignment Faults

This block sits between an execute stage and a 32-bit-wide, byte-addressed data memory. The execute stage gives it an effective address, store data taken from a source register, an access size and a signedness flag. From these it derives a word address, per-lane byte enables, a write strobe and lane-steered write data. The memory answers one cycle later, and the block then picks out the requested bytes and extends them to 32 bits. Byte order is little-endian.

Half-word accesses must sit on an even address and word accesses on a multiple of four. A misaligned or reserved-size access raises a fault flag in the request cycle. It also enables no lanes and writes nothing, and a faulting load answers with zero data. The request side is purely combinational. The response side holds one register stage that tracks a synchronous-read memory.

Top module: `lsu_byte_lane`

## Requirements
- R1: A valid byte access (size code 2'b00) enables only lane addr[1:0]. On a store, the low byte of the store data is placed in that lane and every other lane of the write data is zero.
- R2: A valid half-word access (size code 2'b01) at an even address enables lanes 2*addr[1] and 2*addr[1]+1. On a store, the low half of the store data is placed in those lanes and the other lanes are zero.
- R3: A valid word access (size code 2'b10) at an address with addr[1:0]==0 enables all four lanes, and the write data equals the store data.
- R4: A half-word access with addr[0]==1 raises the fault flag in that cycle, enables no lanes and does not assert the write strobe, so memory is left unchanged.
- R5: A word access with addr[1:0]!=0 raises the fault flag in that cycle, enables no lanes and does not assert the write strobe, so memory is left unchanged.
- R6: The word address presented to memory is always the effective address with its two low bits dropped.
- R7: One cycle after a valid load, the response-valid flag is high. For a signed load (unsigned flag 0), a byte or half-word result is sign-extended from its top bit.
- R8: For an unsigned load (unsigned flag 1), a byte or half-word result is zero-extended.
- R9: A faulting load still produces a response one cycle later, and its data is zero.
- R10: Size code 2'b11 is reserved: it faults at any address and enables no lanes.
- R11: During and right after reset, the response-valid flag is low and the response data is zero.
- R12: When no request is valid, the block enables no lanes, asserts no write strobe and raises no fault. A store also produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_unsigned | input | 1 | 1 = zero-extend load result, 0 = sign-extend |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Byte-lane enables |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word from memory, one cycle after the request |
| fault | output | 1 | Misaligned or reserved-size access in this cycle |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | 32 | Extended load result |

## Verification
The bench sweeps every size code against all four address offsets, with both signedness settings, over a 64-byte memory. The memory is seeded with words whose bytes straddle the sign boundary (0x7F, 0x80, 0xFF, 0x01). This lets sign extension be told apart from zero extension, and it shows any wrong lane choice, because each lane holds a distinct value. Byte and half-word stores are then swept over every offset and read back as whole words. These readbacks show whether the untouched lanes are preserved and whether the steered lane landed in the right place. Misaligned and reserved-size stores are followed by a word readback to prove they wrote nothing.

// File: rtl/lsu_pkg.sv
// Package: shared types for the byte-lane load/store unit.
// Assumes a 32-bit data path split into four 8-bit lanes.
package lsu_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        acc_size_e        size;
        logic             zext;
        logic             fault;
    } rsp_info_t;

endpackage

// File: rtl/lsu_align_check.sv
// Module: lsu_align_check
// Decides whether an access of the given size at the given byte offset
// is legal. Half-words need an even offset and words need offset zero.
// The reserved size code is always illegal. Purely combinational.
module lsu_align_check
    import lsu_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);

    // Purpose: flag illegal size/offset combinations.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = |off;
            default: misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsu_lane_steer.sv
// Module: lsu_lane_steer
// Produces per-lane enables and steers the low bytes of the store source
// into the addressed lanes, little-endian. Lanes that are not enabled
// carry zero. Assumes the caller gates the result with the alignment check.
module lsu_lane_steer
    import lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] lane_data
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HALF_IDX = i / 2;
        localparam int HALF_SUB = i % 2;
        logic [LANE_W-1:0] pick;

        // Purpose: decide whether lane i takes part in this access.
        always_comb begin
            unique case (size)
                SZ_BYTE: lane_en[i] = (off == OFF_W'(i));
                SZ_HALF: lane_en[i] = (off[OFF_W-1] == 1'(HALF_IDX));
                SZ_WORD: lane_en[i] = 1'b1;
                default: lane_en[i] = 1'b0;
            endcase
        end

        // Purpose: choose which source byte lands in lane i.
        always_comb begin
            unique case (size)
                SZ_BYTE: pick = src[LANE_W-1:0];
                SZ_HALF: pick = src[HALF_SUB*LANE_W +: LANE_W];
                default: pick = src[i*LANE_W +: LANE_W];
            endcase
        end

        assign lane_data[i*LANE_W +: LANE_W] = lane_en[i] ? pick : '0;
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Module: lsu_load_extract
// Shifts the addressed bytes of a read word down to bit 0 and extends
// them to the full width. Assumes a non-faulting half-word has an even
// offset and a word has offset zero. Outputs zero when idle or faulted.
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic              active,
    input  rsp_info_t         info,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] shifted;
    logic              byte_msb;
    logic              half_msb;

    assign shifted  = rdata >> {info.off, 3'b000};
    assign byte_msb = shifted[LANE_W-1] & ~info.zext;
    assign half_msb = shifted[2*LANE_W-1] & ~info.zext;

    // Purpose: extend the selected field, or return zero.
    always_comb begin
        if (!active || info.fault) begin
            result = '0;
        end else begin
            unique case (info.size)
                SZ_BYTE: result = {{(DATA_W-LANE_W){byte_msb}}, shifted[LANE_W-1:0]};
                SZ_HALF: result = {{(DATA_W-2*LANE_W){half_msb}}, shifted[2*LANE_W-1:0]};
                default: result = shifted;
            endcase
        end
    end

endmodule

// File: rtl/lsu_byte_lane.sv
// Module: lsu_byte_lane (top)
// Request side is combinational: word address, lane enables, write strobe,
// steered write data and the fault flag all follow the request in the same
// cycle. Response side assumes memory returns the read word one cycle later,
// and registers the request information needed to extract the result.
// Synchronous active-low reset.
module lsu_byte_lane
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              fault,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);

    localparam int WADDR_W = ADDR_W - OFF_W;

    acc_size_e         size;
    logic [OFF_W-1:0]  off;
    logic              misaligned;
    logic [LANES-1:0]  lane_en;
    logic              access_ok;
    rsp_info_t         info_d;
    rsp_info_t         info_q;
    logic              rsp_valid_q;

    assign size = acc_size_e'(req_size);
    assign off  = req_addr[OFF_W-1:0];

    lsu_align_check u_align (
        .size       (size),
        .off        (off),
        .misaligned (misaligned)
    );

    lsu_lane_steer u_steer (
        .size      (size),
        .off       (off),
        .src       (req_wdata),
        .lane_en   (lane_en),
        .lane_data (mem_wdata)
    );

    // Purpose: drive the memory-side request from the decoded access.
    assign access_ok = req_valid & ~misaligned;
    assign mem_addr  = req_addr[ADDR_W-1 -: WADDR_W];
    assign mem_be    = access_ok ? lane_en : '0;
    assign mem_we    = access_ok & req_store;
    assign fault     = req_valid & misaligned;

    assign info_d = '{off: off, size: size, zext: req_unsigned, fault: misaligned};

    // Purpose: hold load information until the memory answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            info_q      <= '{off: '0, size: SZ_BYTE, zext: 1'b0, fault: 1'b0};
        end else begin
            rsp_valid_q <= req_valid & ~req_store;
            if (req_valid && !req_store) begin
                info_q <= info_d;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;

    lsu_load_extract u_extract (
        .active (rsp_valid_q),
        .info   (info_q),
        .rdata  (mem_rdata),
        .result (rsp_data)
    );

    AST_BE_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && size == SZ_BYTE |-> $onehot(mem_be)) // R1
        else $error("byte access lane count");

    AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && size == SZ_HALF && !req_addr[0] |-> (mem_be == 4'b0011 || mem_be == 4'b1100)) // R2
        else $error("half-word lane pair");

    AST_WORD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && size == SZ_WORD && req_addr[1:0] == 2'b00 |-> mem_be == 4'b1111) // R3
        else $error("word lanes");

    AST_HALF_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && size == SZ_HALF && req_addr[0] |-> fault && mem_be == '0 && !mem_we) // R4
        else $error("half-word misalign");

    AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && size == SZ_WORD && req_addr[1:0] != 2'b00 |-> fault && mem_be == '0 && !mem_we) // R5
        else $error("word misalign");

    AST_LOAD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store |=> rsp_valid) // R7
        else $error("missing response");

    AST_UNSIGNED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store && size == SZ_BYTE && req_unsigned |=> rsp_data[31:8] == '0) // R8
        else $error("zero-extension");

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store && fault |=> rsp_valid && rsp_data == '0) // R9
        else $error("faulting load data");

    AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && size == SZ_RSVD |-> fault && mem_be == '0) // R10
        else $error("reserved size");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> mem_be == '0 && !mem_we && !fault) // R12
        else $error("idle activity");

endmodule

// File: tb/tb_lsu_byte_lane.sv
module tb_lsu_byte_lane;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        fault;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] ram    [64];
    logic [7:0] shadow [64];

    always #2 clk = ~clk;

    lsu_byte_lane dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fault(fault), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // synchronous-read memory model, 16 words
    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (mem_we && mem_be[k]) ram[{mem_addr[3:0], 2'(k)}] <= mem_wdata[8*k +: 8];
        end
        mem_rdata <= {ram[{mem_addr[3:0], 2'd3}], ram[{mem_addr[3:0], 2'd2}],
                      ram[{mem_addr[3:0], 2'd1}], ram[{mem_addr[3:0], 2'd0}]};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [1:0] sz, input logic [1:0] o);
        return (sz == 2'b11) || (sz == 2'b01 && o[0]) || (sz == 2'b10 && o != 2'b00);
    endfunction

    task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                          input logic [31:0] a, input logic [31:0] wd);
        logic [1:0]  o;
        bit          bad;
        logic [3:0]  be_exp;
        logic [31:0] wd_exp;
        logic [31:0] word;
        logic [31:0] sel;
        logic [31:0] ld_exp;
        string       tag;
        o   = a[1:0];
        bad = is_bad(sz, o);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        req_addr = a; req_wdata = wd;
        #1;
        tag = (sz == 2'b00) ? "R1" : (sz == 2'b01) ? (bad ? "R4" : "R2") :
              (sz == 2'b10) ? (bad ? "R5" : "R3") : "R10";
        if (bad) begin
            be_exp = 4'b0000; wd_exp = mem_wdata;
        end else if (sz == 2'b00) begin
            be_exp = 4'b0001 << o; wd_exp = {24'h0, wd[7:0]} << (8 * o);
        end else if (sz == 2'b01) begin
            be_exp = 4'b0011 << o; wd_exp = {16'h0, wd[15:0]} << (8 * o);
        end else begin
            be_exp = 4'b1111; wd_exp = wd;
        end
        chk(mem_be == be_exp, tag, {28'h0, mem_be}, {28'h0, be_exp});
        chk(fault == bad, tag, {31'h0, fault}, {31'h0, bad});
        chk(mem_we == (st && !bad), tag, {31'h0, mem_we}, {31'h0, st && !bad});
        if (st && !bad) chk(mem_wdata == wd_exp, tag, mem_wdata, wd_exp);
        chk(mem_addr == a[31:2], "R6", {2'b0, mem_addr}, {2'b0, a[31:2]});
        word = {shadow[{a[5:2], 2'd3}], shadow[{a[5:2], 2'd2}],
                shadow[{a[5:2], 2'd1}], shadow[{a[5:2], 2'd0}]};
        sel  = word >> (8 * o);
        if (bad) ld_exp = '0;
        else if (sz == 2'b00) ld_exp = uns ? {24'h0, sel[7:0]} : {{24{sel[7]}}, sel[7:0]};
        else if (sz == 2'b01) ld_exp = uns ? {16'h0, sel[15:0]} : {{16{sel[15]}}, sel[15:0]};
        else ld_exp = word;
        if (st && !bad) begin
            for (int k = 0; k < 4; k++) begin
                if (be_exp[k]) shadow[{a[5:2], 2'(k)}] = wd_exp[8*k +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (st) begin
            chk(rsp_valid == 1'b0, "R12", {31'h0, rsp_valid}, 32'h0);
        end else begin
            chk(rsp_valid == 1'b1, "R7", {31'h0, rsp_valid}, 32'h1);
            chk(rsp_data == ld_exp, bad ? "R9" : (uns ? "R8" : "R7"), rsp_data, ld_exp);
        end
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h80FF7F01; pats[1] = 32'h017F80FE;
        pats[2] = 32'hFF01807F; pats[3] = 32'h7F80FF00;
        for (int k = 0; k < 64; k++) begin ram[k] = 8'h00; shadow[k] = 8'h00; end
        req_valid = 1'b1; req_size = 2'b10; req_addr = 32'h3;
        repeat (3) @(negedge clk);
        #1;
        chk(rsp_valid == 1'b0 && rsp_data == '0, "R11", rsp_data, 32'h0);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rsp_valid == 1'b0 && rsp_data == '0, "R11", rsp_data, 32'h0);
        req_addr = 32'h1; req_size = 2'b10; req_store = 1'b1;
        #1;
        chk(mem_be == 4'b0 && !mem_we && !fault, "R12", {28'h0, mem_be}, 32'h0);
        // seed memory with word stores
        for (int w = 0; w < 16; w++) access(1'b1, 2'b10, 1'b0, 32'(w * 4), pats[w % 4] ^ 32'(w));
        // full load sweep over sizes, offsets and signedness
        for (int a = 0; a < 16; a++)
            for (int sz = 0; sz < 4; sz++)
                for (int u = 0; u < 2; u++)
                    access(1'b0, 2'(sz), 1'(u), 32'(a), 32'h0);
        // store sweep followed by word readback
        for (int a = 16; a < 32; a++)
            for (int sz = 0; sz < 4; sz++) begin
                access(1'b1, 2'(sz), 1'b0, 32'(a), 32'hA5C3_9600 | 32'(a * 4 + sz));
                access(1'b0, 2'b10, 1'b0, 32'(a & ~1'b1 & ~32'h2), 32'h0);
            end
        // high address bits pass through to the word address
        access(1'b0, 2'b00, 1'b1, 32'hFFFF_FFC5, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule